// File: doc/BRIEF.md
# MultiMediaCard Write-Data Transfer Controller

This block runs the write-data phase of a MultiMediaCard host on a single data line. After the command response to a write command has arrived, software sets an enable bit in a small control register. The block then generates the card clock from the system clock and shifts bytes from a first-word-fall-through transmit FIFO onto the data line. Each block goes out framed by a start bit and a 16-bit CRC.

The card clock is gated under software control. It stops, always in its low phase, when the FIFO has no byte at the moment one is needed. It also stops after every block of a multi-block write except the last. It restarts only when software writes the enable bit again. After each block the controller samples the card's 3-bit CRC status token and raises an error flag if the card reports a fault. It then waits out the card's busy period before it counts the block as done. A command-off bit in the same register abandons the sequence at any point.

Top module: `mmc_wr_xfer`

## Requirements
- R1: After reset the card clock is low, the data driver is off, `fifo_rd`, `crc_err` and `xfer_busy` are 0, and `ctl_rdata` is 0.
- R2: Each block goes out with the bits changing on the card clock's falling edge, in this order: a 0, then `cfg_blk_len` bytes each MSB first, then the 16-bit CRC of those data bits MSB first, then a 1. The CRC uses polynomial x^16+x^12+x^5+1 with initial value 0.
- R3: While running, the card clock period is 2*(`cfg_div`+1) system clocks. The clock stays low while no transfer is running.
- R4: Control register: bit 4 is the data-enable bit and bit 7 the command-off bit, both self-clearing and reading 0. Bit 5 reads 1 while the clock gate is enabled. All other bits read 0.
- R5: A data-enable write is accepted only in three places: after the response pulse `rsp_done`, in a FIFO-empty pause, and in a block-boundary pause. A write with bit 4 at 0, or a data-enable write at any other time, has no effect on the clock or the data.
- R6: If the FIFO is empty when the next byte is needed, the clock stops low and the data stays in order. It resumes on a data-enable write made while the FIFO holds data. A data-enable write made while the FIFO is still empty leaves the pause in place.
- R7: In a multi-block write of `cfg_blk_cnt` blocks, the clock stops low after every block but the last, with the driver off, until a data-enable write. After the last block the controller returns to idle.
- R8: After the end bit the controller waits for a 0 start bit on `mmc_dat_in` and takes the next three bits as the token. Any token other than 010 sets `crc_err`. `crc_err` stays set until the next `rsp_done`.
- R9: After the token's end bit the block completes on the first card-clock rise that sees `mmc_dat_in` high. The clock keeps running while the card holds the line low, so a block costs 8*`cfg_blk_len`+24+B rises for B busy bits.
- R10: A command-off write returns the controller to idle on the next cycle with the driver off, and the clock stops low.
- R11: Every high phase of the card clock lasts exactly `cfg_div`+1 system clocks, including when the clock is paused or aborted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | DIV_W | Card clock half-period minus one, in system clocks |
| cfg_blk_len | input | LEN_W | Bytes per block (at least 1) |
| cfg_blk_cnt | input | CNT_W | Blocks per transfer (at least 1) |
| rsp_done | input | 1 | Pulse: response to a write command received |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| fifo_empty | input | 1 | Transmit FIFO has no byte |
| fifo_rdata | input | DW | Head byte of the transmit FIFO |
| fifo_rd | output | 1 | Pop the head byte |
| mmc_clk | output | 1 | Card clock |
| mmc_dat_out | output | 1 | Data line drive value |
| mmc_dat_oe | output | 1 | Data line driver enable |
| mmc_dat_in | input | 1 | Data line as seen from the card |
| crc_err | output | 1 | Card reported a CRC status error |
| xfer_busy | output | 1 | A write sequence is in progress |

## Verification
The assertions assume that `cfg_div`, `cfg_blk_len` and `cfg_blk_cnt` stay constant while `xfer_busy` is high. They also assume `mmc_dat_in` changes only after a falling card clock edge, as a card would drive it. The bench programs the configuration only while idle. Its card model updates the line only after it sees the clock go low, so the line is stable at every rising edge the controller samples.

// File: rtl/mmc_wr_pkg.sv
package mmc_wr_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_ARMED, ST_START, ST_DATA, ST_CRC,
        ST_END, ST_STAT, ST_BUSY, ST_PEMPTY, ST_PBLK
    } wr_st_t;

    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam int          CTL_DE_BIT  = 4;
    localparam int          CTL_RUN_BIT = 5;
    localparam int          CTL_OFF_BIT = 7;
    localparam logic [2:0]  TOK_OK      = 3'b010;

    function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic b);
        logic fb;
        fb = crc[15] ^ b;
        return {crc[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
    endfunction

endpackage

// File: rtl/mmc_clk_gate.sv
module mmc_clk_gate #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_i,
    input  logic             run_i,
    output logic             mmc_clk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [DIV_W-1:0] cnt_q;
    logic             clk_q;
    logic             en, tick;

    // a high phase is always finished before the gate closes
    assign en     = run_i | clk_q;
    assign tick   = en && (cnt_q == div_i);
    assign rise_o = tick && !clk_q;
    assign fall_o = tick && clk_q;
    assign mmc_clk_o = clk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (!en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R11
    no_runt_chk: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !clk_q) |=> !clk_q);

endmodule

// File: rtl/mmc_crc16.sv
module mmc_crc16 (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic bit_i,
    input  logic sh_i,
    output logic msb_o
);
    import mmc_wr_pkg::*;
    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)  crc_q <= '0;
        else if (en_i)     crc_q <= crc16_step(crc_q, bit_i);
        else if (sh_i)     crc_q <= {crc_q[14:0], 1'b0};
    end

    assign msb_o = crc_q[15];

endmodule

// File: rtl/mmc_wr_seq.sv
module mmc_wr_seq #(
    parameter int DW    = 8,
    parameter int LEN_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] blk_len_i,
    input  logic [CNT_W-1:0] blk_cnt_i,
    input  logic             rsp_done_i,
    input  logic             de_i,
    input  logic             off_i,
    input  logic             fifo_empty_i,
    input  logic [DW-1:0]    fifo_rdata_i,
    output logic             fifo_rd_o,
    input  logic             rise_i,
    input  logic             fall_i,
    input  logic             dat_in_i,
    input  logic             crc_msb_i,
    output logic             crc_clr_o,
    output logic             crc_en_o,
    output logic             crc_bit_o,
    output logic             crc_sh_o,
    output logic             run_o,
    output logic             dat_out_o,
    output logic             dat_oe_o,
    output logic             crc_err_o,
    output logic             busy_o
);
    import mmc_wr_pkg::*;
    localparam int BC_W = (DW > 16) ? $clog2(DW) + 1 : 5;

    wr_st_t           st_q;
    logic [DW-1:0]    sh_q;
    logic [BC_W-1:0]  bitc_q;
    logic [LEN_W-1:0] bytec_q;
    logic [CNT_W-1:0] blkc_q;
    logic             run_q, err_q, tok_got_q;
    logic [1:0]       tokc_q;
    logic [2:0]       tok_q;
    logic             last_bit, last_byte, last_blk, fetch, resume;

    always_comb begin
        last_bit  = (bitc_q == BC_W'(DW - 1));
        last_byte = (bytec_q == blk_len_i - LEN_W'(1));
        last_blk  = (blkc_q == blk_cnt_i - CNT_W'(1));
        fetch     = !off_i && fall_i &&
                    (st_q == ST_START || (st_q == ST_DATA && last_bit && !last_byte));
        resume    = !off_i && st_q == ST_PEMPTY && de_i && !fifo_empty_i;
        fifo_rd_o = (fetch && !fifo_empty_i) || resume;
        crc_clr_o = (st_q == ST_START);
        crc_en_o  = !off_i && fall_i && st_q == ST_DATA;
        crc_bit_o = sh_q[DW-1];
        crc_sh_o  = !off_i && fall_i && st_q == ST_CRC;
        unique case (st_q)
            ST_START: dat_out_o = 1'b0;
            ST_DATA:  dat_out_o = sh_q[DW-1];
            ST_CRC:   dat_out_o = crc_msb_i;
            default:  dat_out_o = 1'b1;
        endcase
        dat_oe_o = st_q inside {ST_START, ST_DATA, ST_CRC, ST_END, ST_PEMPTY};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;  sh_q <= '0;  bitc_q <= '0;  bytec_q <= '0;
            blkc_q <= '0;  run_q <= 1'b0;  err_q <= 1'b0;
            tok_got_q <= 1'b0;  tokc_q <= '0;  tok_q <= '0;
        end else if (off_i) begin
            st_q  <= ST_IDLE;
            run_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (rsp_done_i) begin
                    st_q <= ST_ARMED;  err_q <= 1'b0;  blkc_q <= '0;
                end
                ST_ARMED, ST_PBLK: if (de_i) begin
                    st_q <= ST_START;  run_q <= 1'b1;  bytec_q <= '0;
                end
                ST_START: if (fall_i) begin
                    bitc_q <= '0;
                    if (fifo_empty_i) begin st_q <= ST_PEMPTY; run_q <= 1'b0; end
                    else begin sh_q <= fifo_rdata_i; st_q <= ST_DATA; end
                end
                ST_DATA: if (fall_i) begin
                    sh_q <= sh_q << 1;
                    if (!last_bit) bitc_q <= bitc_q + 1'b1;
                    else begin
                        bitc_q <= '0;
                        if (last_byte) begin bytec_q <= '0; st_q <= ST_CRC; end
                        else begin
                            bytec_q <= bytec_q + 1'b1;
                            if (fifo_empty_i) begin st_q <= ST_PEMPTY; run_q <= 1'b0; end
                            else sh_q <= fifo_rdata_i;
                        end
                    end
                end
                ST_PEMPTY: if (resume) begin
                    sh_q <= fifo_rdata_i;  bitc_q <= '0;  st_q <= ST_DATA;  run_q <= 1'b1;
                end
                ST_CRC: if (fall_i) begin
                    if (bitc_q == BC_W'(15)) begin bitc_q <= '0; st_q <= ST_END; end
                    else bitc_q <= bitc_q + 1'b1;
                end
                ST_END: if (fall_i) begin
                    st_q <= ST_STAT;  tok_got_q <= 1'b0;  tokc_q <= '0;
                end
                ST_STAT: if (rise_i) begin
                    if (!tok_got_q) tok_got_q <= !dat_in_i;
                    else if (tokc_q != 2'd3) begin
                        tok_q  <= {tok_q[1:0], dat_in_i};
                        tokc_q <= tokc_q + 1'b1;
                    end else begin
                        if (tok_q != TOK_OK) err_q <= 1'b1;
                        st_q <= ST_BUSY;
                    end
                end
                ST_BUSY: if (rise_i && dat_in_i) begin
                    run_q <= 1'b0;
                    if (last_blk) st_q <= ST_IDLE;
                    else begin blkc_q <= blkc_q + 1'b1; st_q <= ST_PBLK; end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign run_o     = run_q;
    assign crc_err_o = err_q;
    assign busy_o    = (st_q != ST_IDLE);

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        off_i |=> (st_q == ST_IDLE && !dat_oe_o));
    // R8
    crc_err_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> $past(st_q) == ST_STAT);
    // R6
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PEMPTY && fifo_empty_i) |=> st_q inside {ST_PEMPTY, ST_IDLE});
    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_BUSY && rise_i && !dat_in_i && !off_i) |=> st_q == ST_BUSY);

endmodule

// File: rtl/mmc_wr_xfer.sv
module mmc_wr_xfer #(
    parameter int DW    = 8,
    parameter int DIV_W = 8,
    parameter int LEN_W = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [LEN_W-1:0] cfg_blk_len,
    input  logic [CNT_W-1:0] cfg_blk_cnt,
    input  logic             rsp_done,
    input  logic             ctl_wr,
    input  logic [7:0]       ctl_wdata,
    output logic [7:0]       ctl_rdata,
    input  logic             fifo_empty,
    input  logic [DW-1:0]    fifo_rdata,
    output logic             fifo_rd,
    output logic             mmc_clk,
    output logic             mmc_dat_out,
    output logic             mmc_dat_oe,
    input  logic             mmc_dat_in,
    output logic             crc_err,
    output logic             xfer_busy
);
    import mmc_wr_pkg::*;

    logic de, off, run, rise, fall;
    logic crc_clr, crc_en, crc_bit, crc_sh, crc_msb;

    assign de  = ctl_wr && ctl_wdata[CTL_DE_BIT];
    assign off = ctl_wr && ctl_wdata[CTL_OFF_BIT];

    always_comb begin
        ctl_rdata = '0;
        ctl_rdata[CTL_RUN_BIT] = run;
    end

    mmc_clk_gate #(.DIV_W(DIV_W)) u_gate (
        .clk(clk), .rst(rst), .div_i(cfg_div), .run_i(run),
        .mmc_clk_o(mmc_clk), .rise_o(rise), .fall_o(fall)
    );

    mmc_crc16 u_crc (
        .clk(clk), .rst(rst), .clr_i(crc_clr), .en_i(crc_en),
        .bit_i(crc_bit), .sh_i(crc_sh), .msb_o(crc_msb)
    );

    mmc_wr_seq #(.DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .blk_len_i(cfg_blk_len), .blk_cnt_i(cfg_blk_cnt),
        .rsp_done_i(rsp_done), .de_i(de), .off_i(off),
        .fifo_empty_i(fifo_empty), .fifo_rdata_i(fifo_rdata), .fifo_rd_o(fifo_rd),
        .rise_i(rise), .fall_i(fall), .dat_in_i(mmc_dat_in), .crc_msb_i(crc_msb),
        .crc_clr_o(crc_clr), .crc_en_o(crc_en), .crc_bit_o(crc_bit), .crc_sh_o(crc_sh),
        .run_o(run), .dat_out_o(mmc_dat_out), .dat_oe_o(mmc_dat_oe),
        .crc_err_o(crc_err), .busy_o(xfer_busy)
    );

    // R3
    idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!xfer_busy && !mmc_clk) |=> !mmc_clk);

endmodule

// File: tb/mmc_wr_xfer_tb.sv
`timescale 1ns/1ps
module mmc_wr_xfer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] cfg_div = 8'd2;
    logic [9:0] cfg_blk_len = 10'd4;
    logic [7:0] cfg_blk_cnt = 8'd1;
    logic       rsp_done = 1'b0, ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = 8'h00, ctl_rdata;
    logic       fifo_empty, fifo_rd, mmc_clk, mmc_dat_out, mmc_dat_oe, crc_err, xfer_busy;
    logic [7:0] fifo_rdata;
    logic       mmc_dat_in = 1'b1;

    always #4 clk = ~clk;

    mmc_wr_xfer u_dut (
        .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_blk_len(cfg_blk_len),
        .cfg_blk_cnt(cfg_blk_cnt), .rsp_done(rsp_done), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .fifo_empty(fifo_empty),
        .fifo_rdata(fifo_rdata), .fifo_rd(fifo_rd), .mmc_clk(mmc_clk),
        .mmc_dat_out(mmc_dat_out), .mmc_dat_oe(mmc_dat_oe), .mmc_dat_in(mmc_dat_in),
        .crc_err(crc_err), .xfer_busy(xfer_busy)
    );

    // transmit FIFO model
    logic [7:0] fq [0:255];
    int fh = 0, ft = 0;
    assign fifo_empty = (fh == ft);
    assign fifo_rdata = fq[fh[7:0]];
    always @(posedge clk) if (fifo_rd) fh <= fh + 1;

    logic [7:0] sent [0:255];
    int nsent = 0;

    // card model
    logic bits [0:4095];
    int nbits = 0, rises = 0, cyc = 0, lrise = 0, per = 0;
    int hi_run = 0, hi_bad = 0, rx_cnt = 0, fn = 0, busy_n = 0;
    logic tph = 1'b0, pclk = 1'b0;
    logic [2:0] tok = 3'b010;

    always @(negedge clk) begin
        cyc++;
        if (mmc_clk && !pclk) begin
            rises++;  per = cyc - lrise;  lrise = cyc;
            if (mmc_dat_oe) begin
                bits[nbits] = mmc_dat_out;  nbits++;  rx_cnt++;
                if (rx_cnt == 8 * int'(cfg_blk_len) + 18) begin tph = 1'b1; fn = 0; rx_cnt = 0; end
            end
        end
        if (!mmc_clk && pclk) begin
            if (hi_run != int'(cfg_div) + 1) hi_bad++;
            hi_run = 0;
            if (tph) begin
                fn++;
                if (fn == 1) mmc_dat_in = 1'b0;
                else if (fn <= 4) mmc_dat_in = tok[4 - fn];
                else if (fn == 5) mmc_dat_in = 1'b1;
                else if (fn <= 5 + busy_n) mmc_dat_in = 1'b0;
                else begin mmc_dat_in = 1'b1; tph = 1'b0; end
            end
        end
        if (mmc_clk) hi_run++;
        pclk = mmc_clk;
    end

    int n_chk = 0, n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fq[ft[7:0]] = b;  ft++;
        sent[nsent] = b;  nsent++;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = 8'h00;
    endtask

    task automatic pulse_rsp();
        @(negedge clk); rsp_done = 1'b1;
        @(negedge clk); rsp_done = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && xfer_busy; i++) @(negedge clk);
        repeat (2 * (int'(cfg_div) + 2)) @(negedge clk);
    endtask

    function automatic logic [15:0] crc_of(input int first, input int len);
        logic [15:0] c = '0;
        for (int i = 0; i < len; i++)
            for (int k = 7; k >= 0; k--)
                c = {c[14:0], 1'b0} ^ ((c[15] ^ sent[first + i][k]) ? 16'h1021 : 16'h0);
        return c;
    endfunction

    // checks one framed block in the card's capture
    task automatic chk_block(input int base, input int first, input int len, input string req);
        logic [7:0]  b;
        logic [15:0] c;
        int p = base + 1;
        chk(bits[base] == 1'b0, {req, " start bit"}, int'(bits[base]), 0);
        for (int i = 0; i < len; i++) begin
            for (int k = 0; k < 8; k++) begin b = {b[6:0], bits[p]}; p++; end
            chk(b == sent[first + i], {req, " data byte"}, int'(b), int'(sent[first + i]));
        end
        for (int k = 0; k < 16; k++) begin c = {c[14:0], bits[p]}; p++; end
        chk(c == crc_of(first, len), {req, " crc16"}, int'(c), int'(crc_of(first, len)));
        chk(bits[p] == 1'b1, {req, " end bit"}, int'(bits[p]), 1);
    endtask

    task automatic t_reset();
        chk(mmc_clk == 0 && mmc_dat_oe == 0 && fifo_rd == 0, "R1 clk/oe/rd", int'({mmc_clk, mmc_dat_oe, fifo_rd}), 0);
        chk(crc_err == 0 && xfer_busy == 0, "R1 err/busy", int'({crc_err, xfer_busy}), 0);
        chk(ctl_rdata == 8'h00, "R1 ctl_rdata", int'(ctl_rdata), 0);
    endtask

    task automatic t_single();
        int base = nbits, first = nsent, r0;
        cfg_blk_len = 10'd4; cfg_blk_cnt = 8'd1; tok = 3'b010; busy_n = 0;
        push(8'hA5); push(8'h3C); push(8'hFF); push(8'h01);
        // R5 enable write ignored while idle and before any response
        r0 = rises;
        wr_ctl(8'h10);
        repeat (40) @(negedge clk);
        chk(rises == r0 && !xfer_busy, "R5 de ignored in idle", rises - r0, 0);
        pulse_rsp();
        chk(ctl_rdata[5] == 1'b0, "R4 run bit before enable", int'(ctl_rdata[5]), 0);
        // R5 write with enable bit clear does not start
        wr_ctl(8'h00);
        repeat (40) @(negedge clk);
        chk(rises == r0 && mmc_clk == 0, "R5 zero write no start", rises - r0, 0);
        wr_ctl(8'h10);
        chk(ctl_rdata[4] == 1'b0 && ctl_rdata[5] == 1'b1, "R4 readback", int'(ctl_rdata), 8'h20);
        repeat (30) @(negedge clk);
        wr_ctl(8'h10);  // R5 ignored mid-block
        wait_idle();
        chk_block(base, first, 4, "R2");
        chk(per == 2 * (int'(cfg_div) + 1), "R3 clock period", per, 2 * (int'(cfg_div) + 1));
        chk(rises - r0 == 8 * 4 + 24, "R9 rises no busy", rises - r0, 8 * 4 + 24);
        chk(crc_err == 0, "R8 good token", int'(crc_err), 0);
        chk(!xfer_busy && mmc_clk == 0 && ctl_rdata == 0, "R3 idle clock low", int'({xfer_busy, mmc_clk}), 0);
    endtask

    task automatic t_empty();
        int base = nbits, first = nsent, r0, r1;
        push(8'h81); push(8'h7E);
        pulse_rsp(); wr_ctl(8'h10);
        repeat (250) @(negedge clk);
        r0 = rises;
        chk(mmc_clk == 0 && xfer_busy && ctl_rdata[5] == 0, "R6 paused low", int'({mmc_clk, ctl_rdata[5]}), 0);
        wr_ctl(8'h10);  // still empty: stays paused
        repeat (60) @(negedge clk);
        chk(rises == r0, "R6 empty enable keeps pause", rises - r0, 0);
        push(8'h55); push(8'hC3);
        r1 = rises;
        repeat (20) @(negedge clk);
        chk(rises == r1, "R6 no resume without enable", rises - r1, 0);
        wr_ctl(8'h10);
        wait_idle();
        chk_block(base, first, 4, "R6");
    endtask

    task automatic t_multi();
        int base = nbits, first = nsent, r0;
        cfg_blk_len = 10'd2; cfg_blk_cnt = 8'd2; busy_n = 6;
        push(8'h12); push(8'h34); push(8'h56); push(8'h78);
        r0 = rises;
        pulse_rsp(); wr_ctl(8'h10);
        for (int i = 0; i < 5000 && rises - r0 < 8 * 2 + 24 + 6; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(rises - r0 == 8 * 2 + 24 + 6, "R9 rises with busy", rises - r0, 8 * 2 + 30);
        chk(mmc_clk == 0 && mmc_dat_oe == 0 && xfer_busy, "R7 block pause", int'({mmc_clk, mmc_dat_oe, xfer_busy}), 1);
        wr_ctl(8'h10);
        wait_idle();
        chk_block(base, first, 2, "R7 blk0");
        chk_block(base + 34, first + 2, 2, "R7 blk1");
        chk(!xfer_busy, "R7 idle after last", int'(xfer_busy), 0);
    endtask

    task automatic t_crcerr();
        cfg_blk_len = 10'd1; cfg_blk_cnt = 8'd1; busy_n = 0; tok = 3'b101;
        push(8'h9D);
        pulse_rsp(); wr_ctl(8'h10);
        wait_idle();
        chk(crc_err == 1'b1, "R8 bad token flag", int'(crc_err), 1);
        tok = 3'b010;
        pulse_rsp();
        chk(crc_err == 1'b0, "R8 cleared by response", int'(crc_err), 0);
        wr_ctl(8'h80);
    endtask

    task automatic t_abort();
        int r0;
        cfg_blk_len = 10'd8; cfg_blk_cnt = 8'd1;
        for (int i = 0; i < 8; i++) push(8'(i * 17));
        pulse_rsp(); wr_ctl(8'h10);
        repeat (37) @(negedge clk);
        wr_ctl(8'h80);
        chk(!xfer_busy && !mmc_dat_oe, "R10 idle next cycle", int'({xfer_busy, mmc_dat_oe}), 0);
        repeat (10) @(negedge clk);
        r0 = rises;
        repeat (50) @(negedge clk);
        chk(rises == r0 && mmc_clk == 0, "R10 clock stopped", rises - r0, 0);
        chk(hi_bad == 0, "R11 high phase length", hi_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single();
        t_empty();
        t_multi();
        t_crcerr();
        t_abort();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule